// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog Timer

This block is a memory-mapped watchdog. A free-running timebase counter advances on every clock. A separate interval counter runs only while the watchdog is armed. An interval lasts 2^INTERVAL_LOG2 clock cycles.

When an interval first ends without service, the block sets a state flag and raises an interrupt. If a second interval in a row ends before software services the watchdog, the block drives a system reset pulse. It also latches a reset-status flag that survives the pulse, so software can read the cause afterwards.

Software uses a plain 32-bit word port with write enable, byte address and write data. Reads are combinational from the address. Arming needs two enable bits, which sit at two different register addresses. Service is a write of ones to the flag bits, which clears them and restarts the interval. An optional build parameter makes the enables sticky once the watchdog is armed.

Top module: `dual_expiry_wdog`

## Requirements
- R1: A synchronous active-low reset clears both enables, both flags, the interval count, the reset pulse and the timebase. After reset, every register reads zero, and `wd_irq` and `wd_rst` are low.
- R2: The interval counter runs only while both enable bits are set. Enable A is bit 1 of the control word at offset 0x0. Enable B is bit 0 of the control word at offset 0x0, and the same storage is bit 0 of the auxiliary word at offset 0x4. Clearing either enable stops the counter and returns it to zero.
- R3: The control word at offset 0x0 reads {28'b0, reset-status, state, enable A, enable B}. The word at offset 0x4 reads {31'b0, enable B}. The word at offset 0x8 reads the timebase. Every other address reads zero.
- R4: Arming or servicing the watchdog starts an interval. If no service write follows, the state flag (bit 2) is set at the 2^INTERVAL_LOG2-th rising edge after the edge that started the interval.
- R5: If an interval expires while the state flag is already set, two things happen. First, `wd_rst` goes high for exactly RST_CYCLES cycles, starting after that edge. Second, the reset-status flag (bit 3) is set and holds until software clears it or the block is reset. The state flag stays set, so each further unserviced interval fires another pulse.
- R6: `wd_irq` is high exactly while the state flag is set and both enables are set.
- R7: A service write is a write to offset 0x0 with bit 2 or bit 3 set. It does three things:
  - it clears the state flag if bit 2 is one;
  - it clears the reset-status flag if bit 3 is one;
  - it restarts the interval.

  A zero in bit 2 or bit 3 leaves that flag unchanged.
- R8: A service write sampled on the same edge as an expiry takes priority. The expiry has no effect.
- R9: The timebase increases by one on every clock and wraps. Writes to offset 0x8 do not change it.
- R10: With ENABLE_ONCE set, once both enables are set, writes cannot clear either of them until reset. With ENABLE_ONCE clear, the enables follow the written value.
- R11: Writes to unmapped addresses have no effect. So do writes to any bit of offset 0x4 other than bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte address of the word accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| wd_irq | output | 1 | Interrupt after the first unserviced interval |
| wd_rst | output | 1 | Reset pulse after the second unserviced interval |

## Verification
The bench watches several corner cases:
- The exact edge of the first expiry. A counter off by one moves the state flag a cycle early or late.
- A service write landing on the expiry edge. Wrong priority would set the flag or fire a reset although software serviced in time.
- Arming through only one enable register. A design that combined the enables wrongly would count.
- The sticky enable build, where a design that lets writes through would let software disarm the watchdog.
- The reset-status flag across and after the pulse, and a bad pulse length, which both show in the per-cycle comparison against the behavioural model.

// File: rtl/wdg_pkg.sv
// Shared definitions for the two-stage watchdog: register offsets, the bit
// positions of the control word, and the packed control/status state.
// Assumes byte addressing with word-aligned registers.
package wdg_pkg;
    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_AUX  = 4;
    localparam int unsigned OFS_TB   = 8;

    localparam int BIT_RSTST = 3;
    localparam int BIT_STATE = 2;
    localparam int BIT_ENA   = 1;
    localparam int BIT_ENB   = 0;

    typedef struct packed {
        logic rst_st;
        logic state;
        logic en_a;
        logic en_b;
    } csr_t;
endpackage

// File: rtl/wdg_timebase.sv
// Free-running timebase: counts up by one on every clock and wraps.
// Assumes nothing about its user; it is read-only from the bus.
module wdg_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] tb
);
    // Advance the timebase every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tb <= '0;
        else        tb <= tb + 1'b1;
    end
endmodule

// File: rtl/wdg_interval.sv
// Interval counter: counts 2^N cycles while running, and flags an expiry on
// the cycle the count is at its maximum. A restart clears the count and
// suppresses that cycle's expiry. Assumes run and restart come from
// registered state.
module wdg_interval #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    logic [N-1:0] cnt_q;

    // Count while running; hold at zero when stopped or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run || restart)  cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    // An expiry is the last count of an interval that is not being restarted.
    always_comb expire = run && !restart && (&cnt_q);
endmodule

// File: rtl/wdg_pulse.sv
// Reset pulse shaper: a fire request yields a high output for LEN cycles,
// starting the cycle after the request. Assumes LEN >= 1.
module wdg_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    generate
        if (LEN <= 1) begin : g_single
            // Single-cycle variant: register the request.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse <= 1'b0;
                else        pulse <= fire;
            end
        end else begin : g_stretch
            localparam int CW = $clog2(LEN + 1);
            logic [CW-1:0] left_q;
            // Load the length on fire, then count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)              left_q <= '0;
                else if (fire)           left_q <= CW'(LEN);
                else if (left_q != '0)   left_q <= left_q - 1'b1;
            end
            // The output is high while cycles remain.
            always_comb pulse = (left_q != '0);
        end
    endgenerate
endmodule

// File: rtl/wdg_csr.sv
// Register file of the watchdog. It holds the two enables and the two flags,
// decodes service writes, and muxes the read data. Assumes one write per
// cycle and that expire is never asserted together with a service write.
module wdg_csr
    import wdg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int TB_W        = 32,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    input  logic [TB_W-1:0]   tb,
    output csr_t              csr_q,
    output logic              kick,
    output logic              fire_rst,
    output logic [DATA_W-1:0] rdata
);
    logic sel_ctrl, sel_aux, sel_tb, lock;
    logic unused_wdata;

    // Decode the word addresses.
    always_comb begin
        sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
        sel_aux  = (addr == ADDR_W'(OFS_AUX));
        sel_tb   = (addr == ADDR_W'(OFS_TB));
    end

    // A service write restarts the interval. Enables lock once armed in
    // sticky mode. A second expiry fires the reset.
    always_comb begin
        kick     = wr_en && sel_ctrl && (wdata[BIT_RSTST] || wdata[BIT_STATE]);
        lock     = ENABLE_ONCE && csr_q.en_a && csr_q.en_b;
        fire_rst = expire && csr_q.state;
    end

    assign unused_wdata = ^wdata[DATA_W-1:4];

    // Update the enables from writes and the flags from service and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else begin
            if (wr_en && sel_ctrl) begin
                csr_q.en_a <= lock || wdata[BIT_ENA];
                csr_q.en_b <= lock || wdata[BIT_ENB];
            end else if (wr_en && sel_aux) begin
                csr_q.en_b <= lock || wdata[BIT_ENB];
            end
            if (kick && wdata[BIT_STATE]) csr_q.state  <= 1'b0;
            if (kick && wdata[BIT_RSTST]) csr_q.rst_st <= 1'b0;
            if (expire) begin
                if (csr_q.state) csr_q.rst_st <= 1'b1;
                else             csr_q.state  <= 1'b1;
            end
        end
    end

    // Select the read word; unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        if (sel_ctrl)     rdata[3:0]    = csr_q;
        else if (sel_aux) rdata[BIT_ENB] = csr_q.en_b;
        else if (sel_tb)  rdata          = DATA_W'(tb);
    end
endmodule

// File: rtl/dual_expiry_wdog.sv
// Top of the two-stage watchdog. The first unserviced interval raises the
// state flag and the interrupt; the second raises a reset pulse and the
// reset-status flag. Assumes a synchronous active-low reset and TB_W <= DATA_W.
module dual_expiry_wdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 32,
    parameter int TB_W          = 32,
    parameter int INTERVAL_LOG2 = 16,
    parameter int RST_CYCLES    = 8,
    parameter bit ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wd_irq,
    output logic              wd_rst
);
    csr_t            csr_q;
    logic            running, kick, expire, fire_rst;
    logic [TB_W-1:0] tb_val;

    // The watchdog runs only with both enables set.
    always_comb running = csr_q.en_a && csr_q.en_b;

    wdg_timebase #(.TB_W(TB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tb(tb_val)
    );

    wdg_interval #(.N(INTERVAL_LOG2)) u_ivl (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(kick), .expire(expire)
    );

    wdg_csr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TB_W(TB_W), .ENABLE_ONCE(ENABLE_ONCE)
    ) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .expire(expire), .tb(tb_val), .csr_q(csr_q), .kick(kick),
        .fire_rst(fire_rst), .rdata(rdata)
    );

    wdg_pulse #(.LEN(RST_CYCLES)) u_pls (
        .clk(clk), .rst_n(rst_n), .fire(fire_rst), .pulse(wd_rst)
    );

    // Interrupt: state flag set while armed.
    always_comb wd_irq = csr_q.state && running;
endmodule

// File: rtl/wdg_chk.sv
// Property checker for the two-stage watchdog, bound into the top module.
// Assumes the synchronous active-low reset is held for at least two cycles.
module wdg_chk
    import wdg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int TB_W        = 32,
    parameter int RST_CYCLES  = 8,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input csr_t              csr,
    input logic              running,
    input logic              wd_rst,
    input logic [TB_W-1:0]   tb
);
    int   hi_run;
    logic unused_chk;

    assign unused_chk = ^wdata[DATA_W-1:4] ^ wdata[BIT_ENA] ^ wdata[BIT_ENB];

    // Track the length of the current reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_run <= 0;
        else if (wd_rst) hi_run <= hi_run + 1;
        else             hi_run <= 0;
    end

    AST_RST_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> $past(csr.state)); // R5
    AST_RSTST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr.rst_st && !(wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[BIT_RSTST])) |=> csr.rst_st); // R5
    AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RST_CYCLES); // R5
    AST_STATE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr.state) |-> $past(running)); // R4
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[BIT_STATE]) |=> !csr.state); // R7
    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tb == TB_W'($past(tb) + 1'b1))); // R9
    AST_ONCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ENABLE_ONCE && csr.en_a && csr.en_b) |=> (csr.en_a && csr.en_b)); // R10
endmodule

bind dual_expiry_wdog wdg_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TB_W(TB_W),
    .RST_CYCLES(RST_CYCLES), .ENABLE_ONCE(ENABLE_ONCE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .csr(csr_q), .running(running), .wd_rst(wd_rst), .tb(tb_val)
);

// File: tb/sim_dual_expiry_wdog.sv
`timescale 1ns/1ps
module sim_dual_expiry_wdog;
    localparam int N    = 6;
    localparam int RL   = 3;
    localparam int MAXA = (1 << N) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1, rs0, rs1;

    int n_chk = 0, n_fail = 0, n_rst_edges = 0;
    bit checking = 1'b0;
    bit rs0_prev = 1'b0;

    // Behavioural reference state, one slot per instance (slot 1 is sticky).
    bit          m_ena[2], m_enb[2], m_st[2], m_rs[2];
    int          m_age[2], m_pc[2];
    bit [31:0]   m_tb;

    always #2 clk = ~clk;

    dual_expiry_wdog #(.INTERVAL_LOG2(N), .RST_CYCLES(RL), .ENABLE_ONCE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rd0), .wd_irq(irq0), .wd_rst(rs0));
    dual_expiry_wdog #(.INTERVAL_LOG2(N), .RST_CYCLES(RL), .ENABLE_ONCE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rd1), .wd_irq(irq1), .wd_rst(rs1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int k, input logic [3:0] a);
        if (a == 4'd0) return {28'd0, m_rs[k], m_st[k], m_ena[k], m_enb[k]};
        if (a == 4'd4) return {31'd0, m_enb[k]};
        if (a == 4'd8) return m_tb;
        return 32'd0;
    endfunction

    // Reference model: advance on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_ena[k] = 0; m_enb[k] = 0; m_st[k] = 0; m_rs[k] = 0;
                m_age[k] = 0; m_pc[k] = 0;
            end else begin
                bit run, kick, exp, lock;
                run  = m_ena[k] && m_enb[k];
                kick = wr_en && addr == 4'd0 && (wdata[3] || wdata[2]);
                exp  = run && !kick && m_age[k] == MAXA;
                lock = (k == 1) && run;
                m_age[k] = (!run || kick || m_age[k] == MAXA) ? 0 : m_age[k] + 1;
                if (m_pc[k] > 0) m_pc[k] = m_pc[k] - 1;
                if (kick && wdata[2]) m_st[k] = 0;
                if (kick && wdata[3]) m_rs[k] = 0;
                if (exp) begin
                    if (m_st[k]) begin m_rs[k] = 1; m_pc[k] = RL; end
                    else m_st[k] = 1;
                end
                if (wr_en && addr == 4'd0) begin
                    m_ena[k] = lock || wdata[1];
                    m_enb[k] = lock || wdata[0];
                end else if (wr_en && addr == 4'd4) begin
                    m_enb[k] = lock || wdata[0];
                end
            end
        end
        m_tb = rst_n ? m_tb + 1 : 32'd0;
    end

    // Per-cycle comparison of both instances against the model.
    always @(negedge clk) begin
        if (checking) begin
            check("R6 irq u0", {31'd0, irq0}, {31'd0, m_st[0] && m_ena[0] && m_enb[0]});
            check("R6 irq u1", {31'd0, irq1}, {31'd0, m_st[1] && m_ena[1] && m_enb[1]});
            check("R5 pulse u0", {31'd0, rs0}, {31'd0, m_pc[0] > 0});
            check("R5 pulse u1", {31'd0, rs1}, {31'd0, m_pc[1] > 0});
            check("R3 rdata u0", rd0, exp_rd(0, addr));
            check("R3 rdata u1", rd1, exp_rd(1, addr));
            if (rs0 && !rs0_prev) n_rst_edges++;
            rs0_prev = rs0;
        end
    end

    // Tasks start and end just after a rising edge.
    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic probe(input logic [3:0] a);
        addr = a;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog against a hung run.
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired R1 act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] t1;
        int edges_before;
        idle(1);
        checking = 1'b1;
        idle(3);
        // R1: state right after reset
        probe(4'd0);
        check("R1 ctrl after reset", rd0, 32'd0);
        check("R1 irq after reset", {31'd0, irq0}, 32'd0);
        check("R1 pulse after reset", {31'd0, rs0}, 32'd0);
        rst_n = 1'b1;
        idle(1);
        // R9: the timebase advances every cycle and ignores writes
        probe(4'd8);
        t1 = rd0;
        @(negedge clk);
        check("R9 timebase step", rd0, t1 + 32'd1);
        @(posedge clk); #1;
        wr(4'd8, 32'hDEAD_0000);
        probe(4'd8);
        check("R9 timebase write ignored", rd0, m_tb);
        @(posedge clk); #1;
        // R3: unmapped read returns zero
        probe(4'd12);
        check("R3 unmapped read", rd0, 32'd0);
        @(posedge clk); #1;
        // R11: upper bits of the auxiliary word and unmapped writes are ignored
        wr(4'd4, 32'hFFFF_FFFE);
        wr(4'd12, 32'hFFFF_FFFF);
        probe(4'd0);
        check("R11 ignored writes", rd0, 32'd0);
        @(posedge clk); #1;
        // R2: one enable alone does not run the interval
        wr(4'd0, 32'h2);
        idle(80);
        probe(4'd0);
        check("R2 single enable idle", rd0, 32'h2);
        @(posedge clk); #1;
        // R4: the second enable arms it; the flag rises at exactly 2^N edges
        wr(4'd4, 32'h1);
        idle(63);
        probe(4'd0);
        check("R4 flag not yet set", rd0, 32'h3);
        @(posedge clk); #1;
        probe(4'd0);
        check("R4 flag at expiry", rd0, 32'h7);
        check("R6 irq raised", {31'd0, irq0}, 32'd1);
        @(posedge clk); #1;
        // R7: service clears the state flag and restarts
        wr(4'd0, 32'h7);
        probe(4'd0);
        check("R7 service clears state", rd0, 32'h3);
        @(posedge clk); #1;
        // R5: two unserviced intervals produce a pulse and latch the cause
        edges_before = n_rst_edges;
        idle(140);
        probe(4'd0);
        check("R5 cause latched", rd0, 32'hF);
        check("R5 pulse seen", {31'd0, n_rst_edges > edges_before}, 32'd1);
        @(posedge clk); #1;
        // R7: clear state only, then reset-status only
        wr(4'd0, 32'h7);
        probe(4'd0);
        check("R7 state cleared, cause kept", rd0, 32'hB);
        @(posedge clk); #1;
        wr(4'd0, 32'hB);
        probe(4'd0);
        check("R7 cause cleared", rd0, 32'h3);
        @(posedge clk); #1;
        // R8: service on the expiry edge wins
        while (m_age[0] != MAXA) idle(1);
        wr(4'd0, 32'h7);
        probe(4'd0);
        check("R8 service beats expiry", rd0, 32'h3);
        @(posedge clk); #1;
        // R2: stopping through both registers
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0);
        edges_before = n_rst_edges;
        idle(200);
        probe(4'd0);
        check("R2 stopped u0", rd0, 32'h0);
        check("R2 no pulse while stopped", n_rst_edges, edges_before);
        @(posedge clk); #1;
        // R10: the sticky build keeps its enables, the plain build drops them
        wr(4'd0, 32'h2);
        wr(4'd4, 32'h1);
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0);
        probe(4'd0);
        check("R10 sticky enables held", rd1 & 32'h3, 32'h3);
        check("R10 plain enables cleared", rd0 & 32'h3, 32'h0);
        @(posedge clk); #1;
        // R1: reset releases the sticky enables
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        probe(4'd0);
        check("R1 reset releases sticky", rd1, 32'h0);
        @(posedge clk); #1;
        idle(2);
        finish_run();
    end
endmodule